// File: doc/BRIEF.md
# DAC Sample Double Buffer

This block is the digital front end of a DAC sample path. Samples are held in two registers. Software or a DMA engine writes the next sample into a holding register. The converter reads its input from a conversion register, which changes only when an external start strobe arrives. On each enabled strobe, the held sample moves into the conversion register and a one-cycle conversion-start pulse goes out.

When the move leaves the holding register empty, three things happen. The block raises a DMA request, sets a sticky empty flag, and can emit an empty event pulse. A strobe that finds nothing held does not touch the converter; it sets a sticky underrun flag instead. A write-protect input blocks sample writes, and a control bit can override it. A single interrupt line combines the flags with their enable bits.

Top module: `dac_sample_stager`

## Requirements
- R1: After reset the conversion output is CONV_INIT (0 by default), the holding register counts as empty, and dma_req, conv_start, empty_evt, both flags and irq are all 0.
- R2: When start_evt is high at an edge, the start-enable bit is set and a sample is held, the held sample appears on conv_data after that edge. conv_start is 1 for exactly that one following cycle.
- R3: While the start-enable bit (control register, address 0, bit 0) is 0, start_evt has no effect on any output.
- R4: An enabled start_evt with nothing held sets flag_underrun. It leaves conv_data unchanged and produces no conv_start pulse.
- R5: empty_evt pulses for one cycle together with conv_start, but only when the empty-event enable bit (address 0, bit 1) was 1 at the strobe.
- R6: Every transfer sets flag_empty. irq is 1 whenever a flag is set and its enable bit is 1; the enable bits are at address 1, with bit 0 for empty and bit 1 for underrun.
- R7: dma_req is 0 from reset. It goes to 1 after a transfer empties the holding register, and it returns to 0 only after an accepted write to the sample register (address 3, low DATA_W bits).
- R8: While wr_protect is 1, sample writes are ignored unless the bypass bit (address 0, bit 2) is 1.
- R9: Writing 1 to a bit at address 2 clears the matching flag (bit 0 empty, bit 1 underrun). If a set and a clear of the same flag happen in one cycle, the flag stays set.
- R10: A sample write in the same cycle as a transfer lands after the transfer. The old sample goes to the converter, the new one stays held, and dma_req ends at 0.
- R11: A sample write while a sample is already held replaces that sample, and the next transfer uses the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | BUS_W | Write data |
| wr_protect | input | 1 | Peripheral write protection for the sample register |
| start_evt | input | 1 | Start-conversion strobe |
| conv_data | output | DATA_W | Sample presented to the converter |
| conv_start | output | 1 | One-cycle conversion start pulse |
| empty_evt | output | 1 | One-cycle buffer-empty event |
| dma_req | output | 1 | DMA request level |
| flag_empty | output | 1 | Sticky buffer-empty flag |
| flag_underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a single edge on which several rules meet: a strobe, a sample write and a flag clear all arrive together. Ordered stimulus makes this happen. The bench first writes a sample. It then fires a strobe in the very cycle that carries a new sample write, or a write-one-to-clear of the flag the strobe is about to set. Protected writes are checked the same way. A blocked write followed by a strobe shows up as an underrun, so the ignored data becomes visible at the outputs.

// File: rtl/dac_stg_pkg.sv
package dac_stg_pkg;
   localparam int unsigned REG_ADDR_W = 2;
   localparam int unsigned NUM_FLAGS  = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      SEL_CTRL    = 2'd0,
      SEL_INTEN   = 2'd1,
      SEL_FLAGCLR = 2'd2,
      SEL_SAMPLE  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic wp_bypass;
      logic empty_evt_en;
      logic start_en;
   } ctrl_t;

   typedef struct packed {
      logic underrun;
      logic empty;
   } flag_t;
endpackage

// File: rtl/dac_stg_regs.sv
module dac_stg_regs
   import dac_stg_pkg::*;
#(
   parameter int unsigned BUS_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]      wr_data,
   input  logic                  wr_protect,
   output ctrl_t                 ctrl_q,
   output flag_t                 inten_q,
   output flag_t                 clr_mask,
   output logic                  sample_wr
);
   localparam int unsigned CTRL_W = $bits(ctrl_t);
   localparam int unsigned FLG_W  = $bits(flag_t);

   logic sel_ctrl, sel_inten, sel_clr, sel_sample;

   always_comb begin
      sel_ctrl   = wr_en && (wr_addr == SEL_CTRL);
      sel_inten  = wr_en && (wr_addr == SEL_INTEN);
      sel_clr    = wr_en && (wr_addr == SEL_FLAGCLR);
      sel_sample = wr_en && (wr_addr == SEL_SAMPLE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         inten_q <= '0;
      end else begin
         if (sel_ctrl)  ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (sel_inten) inten_q <= flag_t'(wr_data[FLG_W-1:0]);
      end
   end

   always_comb begin
      clr_mask  = sel_clr ? flag_t'(wr_data[FLG_W-1:0]) : '0;
      sample_wr = sel_sample && (!wr_protect || ctrl_q.wp_bypass);
   end
endmodule

// File: rtl/dac_stg_buffer.sv
module dac_stg_buffer #(
   parameter int unsigned DATA_W    = 12,
   parameter logic [DATA_W-1:0] CONV_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_fire,
   input  logic              empty_evt_en,
   input  logic              sample_wr,
   input  logic [DATA_W-1:0] sample_data,
   output logic [DATA_W-1:0] conv_data,
   output logic              conv_start,
   output logic              empty_evt,
   output logic              dma_req,
   output logic              xfer,
   output logic              starve
);
   logic [DATA_W-1:0] hold_q;
   logic              hold_full;

   always_comb begin
      xfer   = start_fire && hold_full;
      starve = start_fire && !hold_full;
   end

   // holding stage: a write in the transfer cycle lands after the move
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q    <= '0;
         hold_full <= 1'b0;
      end else if (sample_wr) begin
         hold_q    <= sample_data;
         hold_full <= 1'b1;
      end else if (xfer) begin
         hold_full <= 1'b0;
      end
   end

   // conversion stage and its strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         conv_data  <= CONV_INIT;
         conv_start <= 1'b0;
         empty_evt  <= 1'b0;
      end else begin
         if (xfer) conv_data <= hold_q;
         conv_start <= xfer;
         empty_evt  <= xfer && empty_evt_en;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dma_req <= 1'b0;
      else if (sample_wr) dma_req <= 1'b0;
      else if (xfer)      dma_req <= 1'b1;
   end
endmodule

// File: rtl/dac_stg_irq.sv
module dac_stg_irq #(
   parameter int unsigned NUM = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set_i,
   input  logic [NUM-1:0] clr_i,
   input  logic [NUM-1:0] en_i,
   output logic [NUM-1:0] flags_q,
   output logic           irq
);
   for (genvar g = 0; g < NUM; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags_q[g] <= 1'b0;
         else if (set_i[g]) flags_q[g] <= 1'b1;
         else if (clr_i[g]) flags_q[g] <= 1'b0;
      end
   end

   always_comb irq = |(flags_q & en_i);
endmodule

// File: rtl/dac_sample_stager.sv
module dac_sample_stager
   import dac_stg_pkg::*;
#(
   parameter int unsigned DATA_W    = 12,
   parameter int unsigned BUS_W     = 16,
   parameter logic [DATA_W-1:0] CONV_INIT = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic              wr_protect,
   input  logic              start_evt,
   output logic [DATA_W-1:0] conv_data,
   output logic              conv_start,
   output logic              empty_evt,
   output logic              dma_req,
   output logic              flag_empty,
   output logic              flag_underrun,
   output logic              irq
);
   localparam int unsigned MIN_BUS = $bits(ctrl_t);

   if (DATA_W < 1 || DATA_W > BUS_W) begin : g_bad_data_w
      $error("DATA_W must lie in 1..BUS_W");
   end
   if (BUS_W < MIN_BUS) begin : g_bad_bus_w
      $error("BUS_W too narrow for control fields");
   end

   ctrl_t ctrl_q;
   flag_t inten_q, clr_mask, set_mask, flags_q;
   logic  sample_wr, xfer, starve, start_fire;

   dac_stg_regs #(.BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_protect(wr_protect), .ctrl_q(ctrl_q),
      .inten_q(inten_q), .clr_mask(clr_mask), .sample_wr(sample_wr)
   );

   always_comb start_fire = start_evt && ctrl_q.start_en;

   dac_stg_buffer #(.DATA_W(DATA_W), .CONV_INIT(CONV_INIT)) u_buf (
      .clk(clk), .rst_n(rst_n), .start_fire(start_fire),
      .empty_evt_en(ctrl_q.empty_evt_en), .sample_wr(sample_wr),
      .sample_data(wr_data[DATA_W-1:0]), .conv_data(conv_data),
      .conv_start(conv_start), .empty_evt(empty_evt), .dma_req(dma_req),
      .xfer(xfer), .starve(starve)
   );

   always_comb begin
      set_mask.empty    = xfer;
      set_mask.underrun = starve;
   end

   dac_stg_irq #(.NUM(NUM_FLAGS)) u_irq (
      .clk(clk), .rst_n(rst_n), .set_i(set_mask), .clr_i(clr_mask),
      .en_i(inten_q), .flags_q(flags_q), .irq(irq)
   );

   always_comb begin
      flag_empty    = flags_q.empty;
      flag_underrun = flags_q.underrun;
   end
endmodule

// File: rtl/dac_stg_checker.sv
module dac_stg_checker #(
   parameter int unsigned DATA_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_evt,
   input logic              start_en,
   input logic              wp_bypass,
   input logic              wr_en,
   input logic [1:0]        wr_addr,
   input logic              wr_protect,
   input logic [DATA_W-1:0] conv_data,
   input logic              conv_start,
   input logic              empty_evt,
   input logic              dma_req,
   input logic              flag_underrun
);
   p_start_from_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(start_evt && start_en));

   p_conv_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_start |-> $stable(conv_data));

   p_underrun_no_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_underrun) |-> !conv_start);

   p_event_with_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      empty_evt |-> conv_start);

   p_dma_cleared_by_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> $past(wr_en && wr_addr == 2'd3));

   p_protect_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_req) |-> $past(!wr_protect || wp_bypass));
endmodule

bind dac_sample_stager dac_stg_checker #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_evt(start_evt),
   .start_en(ctrl_q.start_en), .wp_bypass(ctrl_q.wp_bypass),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_protect(wr_protect),
   .conv_data(conv_data), .conv_start(conv_start), .empty_evt(empty_evt),
   .dma_req(dma_req), .flag_underrun(flag_underrun)
);

// File: tb/test_dac_sample_stager.sv
module test_dac_sample_stager;
   localparam int DW = 12;
   localparam int BW = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, wr_protect = 1'b0, start_evt = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [BW-1:0] wr_data = '0;
   logic [DW-1:0] conv_data;
   logic conv_start, empty_evt, dma_req, flag_empty, flag_underrun, irq;

   always #10 clk = ~clk;

   dac_sample_stager #(.DATA_W(DW), .BUS_W(BW)) i_dac_sample_stager (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_protect(wr_protect), .start_evt(start_evt),
      .conv_data(conv_data), .conv_start(conv_start), .empty_evt(empty_evt),
      .dma_req(dma_req), .flag_empty(flag_empty),
      .flag_underrun(flag_underrun), .irq(irq)
   );

   // behavioural reference
   int m_held[$];
   int m_conv = 0;
   bit m_pulse = 0, m_eevt = 0, m_dma = 0, m_fe = 0, m_fu = 0;
   bit c_start = 0, c_eevt = 0, c_byp = 0, ie_e = 0, ie_u = 0;
   int compared = 0, mismatched = 0;
   string cur_req = "R1";

   task automatic cmp(input string what, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare_all();
      cmp("conv_data(R2)", conv_data, m_conv);
      cmp("conv_start(R2)", conv_start, m_pulse);
      cmp("empty_evt(R5)", empty_evt, m_eevt);
      cmp("dma_req(R7)", dma_req, m_dma);
      cmp("flag_empty(R6)", flag_empty, m_fe);
      cmp("flag_underrun(R4)", flag_underrun, m_fu);
      cmp("irq(R6)", irq, (m_fe && ie_e) || (m_fu && ie_u));
   endtask

   task automatic step(input bit we, input bit [1:0] a, input int d,
                       input bit prot, input bit ev);
      bit fire, set_e, set_u;
      wr_en = we; wr_addr = a; wr_data = BW'(d); wr_protect = prot; start_evt = ev;
      @(posedge clk);
      fire = ev && c_start;
      set_e = 0; set_u = 0;
      m_pulse = 0; m_eevt = 0;
      if (fire) begin
         if (m_held.size() > 0) begin
            m_conv = m_held.pop_front();
            m_pulse = 1; m_eevt = c_eevt; m_dma = 1; set_e = 1;
         end else set_u = 1;
      end
      if (we && a == 2'd2) begin
         if (d[0]) m_fe = 0;
         if (d[1]) m_fu = 0;
      end
      if (set_e) m_fe = 1;
      if (set_u) m_fu = 1;
      if (we && a == 2'd3 && (!prot || c_byp)) begin
         m_held.delete();
         m_held.push_back(d & ((1 << DW) - 1));
         m_dma = 0;
      end
      if (we && a == 2'd0) begin c_start = d[0]; c_eevt = d[1]; c_byp = d[2]; end
      if (we && a == 2'd1) begin ie_e = d[0]; ie_u = d[1]; end
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(); step(0, 0, 0, 0, 0); endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compare_all();
      rst_n = 1'b1;
      idle(); idle();

      cur_req = "R3";           // strobe ignored while start disabled
      step(1, 3, 'h155, 0, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R2";           // enable start and empty event, transfer
      step(1, 0, 3, 0, 0);
      step(1, 1, 3, 0, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R4";           // strobe with nothing held
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R9";           // clear flags, then clear versus set in one cycle
      step(1, 2, 3, 0, 0);
      step(1, 2, 2, 0, 1);
      step(1, 2, 2, 0, 0);

      cur_req = "R7";           // write clears request; back-to-back transfers
      step(1, 3, 'hABC, 0, 0);
      step(0, 0, 0, 0, 1);
      step(1, 3, 'h0FF, 0, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R5";           // empty event disabled
      step(1, 0, 1, 0, 0);
      step(1, 3, 'h777, 0, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R8";           // protected write ignored, then bypass
      step(1, 3, 'h321, 1, 0);
      step(0, 0, 0, 0, 1);
      step(1, 0, 5, 0, 0);
      step(1, 3, 'h456, 1, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R10";          // write coincides with transfer
      step(1, 0, 3, 0, 0);
      step(1, 3, 'h111, 0, 0);
      step(1, 3, 'h222, 0, 1);
      idle();
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R11";          // overwrite of held sample
      step(1, 3, 'h9A1, 0, 0);
      step(1, 3, 'hFFFF, 0, 0);
      step(0, 0, 0, 0, 1);
      idle();

      cur_req = "R6";           // interrupt enables gate irq
      step(1, 1, 0, 0, 0);
      step(1, 1, 1, 0, 0);
      step(1, 1, 2, 0, 0);
      step(1, 2, 3, 0, 0);
      idle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule